// File: doc/BRIEF.md
# Per-Plane Endpoint Packet Forwarder

This block is the small switch that sits inside an accelerator node on a two-dimensional board mesh. The node has several independent network planes. Each plane has four directional ports (East, West, North, South) plus a local inject input and a local eject output. A packet that enters a plane is delivered to the local node, or it leaves on one of that same plane's other directional ports. It never returns on the port it arrived on, and it never moves from one plane to another.

Output selection is dimension-ordered. The X coordinate is corrected first, through East or West. The Y coordinate is corrected next, through North or South. When both coordinates match the node's own coordinate, the packet goes to eject. Each input port holds a small FIFO. Each output port has a round-robin arbiter that keeps its grant on one packet until that packet's last flit has gone out. Every port uses a valid/ready handshake, and no flit is ever dropped.

Top module: `fwd_node`

## Requirements
- R1: While reset is asserted and directly after it, every `out_valid` bit is 0 and every `in_ready` bit is 1.
- R2: The header flit carries destination X in bits [3:0], destination Y in bits [7:4], and in bits [15:8] the number of body flits that follow the header. Port index 0 is East, 1 is West, 2 is North, 3 is South and 4 is local (inject on the input side, eject on the output side). When destination X is greater than the node's X, the packet leaves on East. When destination X is smaller than the node's X, it leaves on West.
- R3: When destination X equals the node's X, the packet leaves on North if destination Y is greater than the node's Y, and on South if destination Y is smaller.
- R4: A packet whose destination equals the node coordinate leaves on the eject port.
- R5: A packet never leaves on its arrival port. If a packet that arrived on a directional port would route back out of that same port, it is delivered to eject instead.
- R6: A packet that enters plane p appears only on the outputs of plane p. In each vector test exactly one output of the whole node is valid.
- R7: Once an output has sent a header, it sends all of that packet's flits, in order, with no flit from another packet between them.
- R8: Each output arbitrates round-robin. After reset the search starts at input 0. After a packet is granted, the search starts at the input just above the winner. Two inputs that each hold two queued packets for the same output are therefore served alternately.
- R9: While `out_ready` is low, a valid output keeps its valid and its data unchanged. Each input accepts up to 4 flits while stalled, then drops `in_ready`. All queued flits come out in order once the stall ends.
- R10: When the target output is idle and ready, a flit accepted on one clock edge is presented at that output before the following clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| my_x | input | 4 | X coordinate of this node |
| my_y | input | 4 | Y coordinate of this node |
| in_valid | input | NPLANE*5 | Per plane and port: flit offered (index plane*5+port) |
| in_data | input | NPLANE*5*16 | Per plane and port: flit contents |
| in_ready | output | NPLANE*5 | Per plane and port: the input FIFO can take a flit |
| out_valid | output | NPLANE*5 | Per plane and port: flit presented |
| out_data | output | NPLANE*5*16 | Per plane and port: presented flit |
| out_ready | input | NPLANE*5 | Per plane and port: downstream takes the flit |

## Verification
The embedded properties check the following on every cycle:
- no output carries a grant from its own input (no U-turn);
- output valid and data stay stable under backpressure;
- grants stay one-hot and stay locked inside a packet;
- no FIFO overflows or underflows;
- the body counter stays consistent.

Some behaviour only the bench scenarios can show:
- the routing decision for each coordinate relation;
- plane isolation;
- the exact order of flits when two packets contend, which shows both contiguity and round-robin alternation;
- recovery without loss after a full input FIFO.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
   localparam int NPORT   = 5;
   localparam int COORD_W = 4;
   localparam int LEN_W   = 8;
   localparam int HDR_W   = 2 * COORD_W + LEN_W;

   localparam logic [2:0] PORT_E   = 3'd0;
   localparam logic [2:0] PORT_W   = 3'd1;
   localparam logic [2:0] PORT_N   = 3'd2;
   localparam logic [2:0] PORT_S   = 3'd3;
   localparam logic [2:0] PORT_LOC = 3'd4;
endpackage

// File: rtl/fwd_fifo.sv
module fwd_fifo #(
   parameter int W     = 16,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push_valid,
   input  logic [W-1:0] push_data,
   output logic         push_ready,
   output logic         pop_valid,
   output logic [W-1:0] pop_data,
   input  logic         pop_en
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 2) begin : g_bad_depth
      $error("fwd_fifo: DEPTH must be at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_q, rd_q, wr_nxt, rd_nxt;
   logic [AW:0]   cnt_q;
   logic          push;

   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_nxt = wr_q + 1'b1;
      assign rd_nxt = rd_q + 1'b1;
   end else begin : g_wrap
      assign wr_nxt = (int'(wr_q) == DEPTH - 1) ? '0 : wr_q + 1'b1;
      assign rd_nxt = (int'(rd_q) == DEPTH - 1) ? '0 : rd_q + 1'b1;
   end

   assign push_ready = (int'(cnt_q) != DEPTH);
   assign pop_valid  = (cnt_q != '0);
   assign pop_data   = mem[rd_q];
   assign push       = push_valid && push_ready;

   always_ff @(posedge clk) begin
      if (push) mem[wr_q] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push)   wr_q <= wr_nxt;
         if (pop_en) rd_q <= rd_nxt;
         case ({push, pop_en})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   p_fifo_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt_q) <= DEPTH);
   p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pop_en |-> pop_valid);
endmodule

// File: rtl/fwd_route.sv
module fwd_route
   import fwd_pkg::*;
#(
   parameter int W       = 16,
   parameter int PORT_ID = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [COORD_W-1:0] my_x,
   input  logic [COORD_W-1:0] my_y,
   input  logic               head_valid,
   input  logic [W-1:0]       head_data,
   input  logic               xfer,
   output logic [2:0]         dest,
   output logic               last
);
   logic [COORD_W-1:0] dx, dy;
   logic [LEN_W-1:0]   len;
   logic [2:0]         dor_port, hdr_port, route_q;
   logic [LEN_W-1:0]   remain_q;
   logic               in_pkt_q;

   assign dx  = head_data[COORD_W-1:0];
   assign dy  = head_data[2*COORD_W-1:COORD_W];
   assign len = head_data[2*COORD_W+LEN_W-1:2*COORD_W];

   always_comb begin
      if (dx > my_x)      dor_port = PORT_E;
      else if (dx < my_x) dor_port = PORT_W;
      else if (dy > my_y) dor_port = PORT_N;
      else if (dy < my_y) dor_port = PORT_S;
      else                dor_port = PORT_LOC;
   end

   if (PORT_ID == int'(PORT_LOC)) begin : g_local
      assign hdr_port = dor_port;
   end else begin : g_dir
      assign hdr_port = (dor_port == 3'(PORT_ID)) ? PORT_LOC : dor_port;
   end

   assign dest = in_pkt_q ? route_q : hdr_port;
   assign last = in_pkt_q ? (remain_q == LEN_W'(1)) : (len == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_pkt_q <= 1'b0;
         remain_q <= '0;
         route_q  <= PORT_LOC;
      end else if (xfer) begin
         if (!in_pkt_q) begin
            if (len != '0) begin
               in_pkt_q <= 1'b1;
               remain_q <= len;
               route_q  <= hdr_port;
            end
         end else begin
            remain_q <= remain_q - 1'b1;
            if (remain_q == LEN_W'(1)) in_pkt_q <= 1'b0;
         end
      end
   end

   p_body_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
      in_pkt_q |-> remain_q != '0);
   p_xfer_needs_head_r7: assert property (@(posedge clk) disable iff (!rst_n)
      xfer |-> head_valid);
endmodule

// File: rtl/fwd_arb.sv
module fwd_arb #(
   parameter int N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   input  logic [N-1:0] last,
   input  logic         ready,
   output logic [N-1:0] gnt,
   output logic         xfer
);
   localparam int IW = (N > 1) ? $clog2(N) : 1;

   logic [IW-1:0] ptr_q, pick_idx, ptr_nxt;
   logic [N-1:0]  pick, owner_q;
   logic          any_req, busy_q, last_sel;

   always_comb begin
      pick     = '0;
      pick_idx = ptr_q;
      any_req  = 1'b0;
      for (int k = 0; k < N; k++) begin
         if (!any_req && req[(int'(ptr_q) + k) % N]) begin
            any_req  = 1'b1;
            pick_idx = IW'((int'(ptr_q) + k) % N);
            pick[(int'(ptr_q) + k) % N] = 1'b1;
         end
      end
   end

   assign ptr_nxt  = (int'(pick_idx) == N - 1) ? '0 : pick_idx + 1'b1;
   assign gnt      = busy_q ? owner_q : pick;
   assign xfer     = ready && |(gnt & req);
   assign last_sel = |(gnt & last);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q   <= '0;
         busy_q  <= 1'b0;
         owner_q <= '0;
      end else if (!busy_q) begin
         if (any_req) begin
            ptr_q <= ptr_nxt;
            if (!(xfer && last_sel)) begin
               busy_q  <= 1'b1;
               owner_q <= pick;
            end
         end
      end else if (xfer && last_sel) begin
         busy_q <= 1'b0;
      end
   end

   p_onehot_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));
   p_pkt_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer && !last_sel) |=> $stable(gnt));
endmodule

// File: rtl/fwd_plane.sv
module fwd_plane
   import fwd_pkg::*;
#(
   parameter int W     = 16,
   parameter int DEPTH = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [COORD_W-1:0] my_x,
   input  logic [COORD_W-1:0] my_y,
   input  logic [NPORT-1:0]   in_valid,
   input  logic [NPORT*W-1:0] in_data,
   output logic [NPORT-1:0]   in_ready,
   output logic [NPORT-1:0]   out_valid,
   output logic [NPORT*W-1:0] out_data,
   input  logic [NPORT-1:0]   out_ready
);
   logic [NPORT-1:0] head_valid, lastv, pop, xfer;
   logic [W-1:0]     hd  [NPORT];
   logic [2:0]       dst [NPORT];
   logic [NPORT-1:0] req_m [NPORT];
   logic [NPORT-1:0] gnt_m [NPORT];

   for (genvar i = 0; i < NPORT; i++) begin : g_in
      fwd_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
         .clk        (clk),
         .rst_n      (rst_n),
         .push_valid (in_valid[i]),
         .push_data  (in_data[i*W +: W]),
         .push_ready (in_ready[i]),
         .pop_valid  (head_valid[i]),
         .pop_data   (hd[i]),
         .pop_en     (pop[i])
      );
      fwd_route #(.W(W), .PORT_ID(i)) u_route (
         .clk        (clk),
         .rst_n      (rst_n),
         .my_x       (my_x),
         .my_y       (my_y),
         .head_valid (head_valid[i]),
         .head_data  (hd[i]),
         .xfer       (pop[i]),
         .dest       (dst[i]),
         .last       (lastv[i])
      );
   end

   always_comb begin
      for (int o = 0; o < NPORT; o++) begin
         for (int i = 0; i < NPORT; i++) begin
            req_m[o][i] = head_valid[i] && (dst[i] == 3'(o));
         end
      end
   end

   for (genvar o = 0; o < NPORT; o++) begin : g_out
      fwd_arb #(.N(NPORT)) u_arb (
         .clk   (clk),
         .rst_n (rst_n),
         .req   (req_m[o]),
         .last  (lastv),
         .ready (out_ready[o]),
         .gnt   (gnt_m[o]),
         .xfer  (xfer[o])
      );

      p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid[o] && !out_ready[o]) |=>
            (out_valid[o] && $stable(out_data[o*W +: W])));

      if (o < NPORT - 1) begin : g_dir
         p_no_uturn_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !(out_valid[o] && gnt_m[o][o]));
      end
   end

   always_comb begin
      pop      = '0;
      out_data = '0;
      for (int o = 0; o < NPORT; o++) begin
         out_valid[o] = |(gnt_m[o] & req_m[o]);
         for (int i = 0; i < NPORT; i++) begin
            if (xfer[o] && gnt_m[o][i]) pop[i] = 1'b1;
            if (gnt_m[o][i]) out_data[o*W +: W] = out_data[o*W +: W] | hd[i];
         end
      end
   end
endmodule

// File: rtl/fwd_node.sv
module fwd_node
   import fwd_pkg::*;
#(
   parameter int NPLANE = 4,
   parameter int FLIT_W = 16,
   parameter int DEPTH  = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [COORD_W-1:0]            my_x,
   input  logic [COORD_W-1:0]            my_y,
   input  logic [NPLANE*NPORT-1:0]        in_valid,
   input  logic [NPLANE*NPORT*FLIT_W-1:0] in_data,
   output logic [NPLANE*NPORT-1:0]        in_ready,
   output logic [NPLANE*NPORT-1:0]        out_valid,
   output logic [NPLANE*NPORT*FLIT_W-1:0] out_data,
   input  logic [NPLANE*NPORT-1:0]        out_ready
);
   localparam int SLICE = NPORT * FLIT_W;

   if (NPLANE < 1) begin : g_bad_planes
      $error("fwd_node: NPLANE must be at least 1");
   end
   if (FLIT_W < HDR_W) begin : g_bad_width
      $error("fwd_node: FLIT_W too narrow for the header fields");
   end

   for (genvar p = 0; p < NPLANE; p++) begin : g_plane
      fwd_plane #(.W(FLIT_W), .DEPTH(DEPTH)) u_plane (
         .clk       (clk),
         .rst_n     (rst_n),
         .my_x      (my_x),
         .my_y      (my_y),
         .in_valid  (in_valid[p*NPORT +: NPORT]),
         .in_data   (in_data[p*SLICE +: SLICE]),
         .in_ready  (in_ready[p*NPORT +: NPORT]),
         .out_valid (out_valid[p*NPORT +: NPORT]),
         .out_data  (out_data[p*SLICE +: SLICE]),
         .out_ready (out_ready[p*NPORT +: NPORT])
      );
   end
endmodule

// File: tb/sim_fwd_node.sv
module sim_fwd_node;
   localparam int CLK_PERIOD = 10;
   localparam int NPL = 4;
   localparam int NP  = 5;
   localparam int FW  = 16;
   localparam int NV  = 12;

   // {plane, input port, dest x, dest y, expected output port}; node sits at (5,5)
   localparam logic [19:0] VEC [NV] = '{
      {4'd0, 4'd4, 4'd7, 4'd2, 4'd0},
      {4'd0, 4'd4, 4'd2, 4'd9, 4'd1},
      {4'd0, 4'd4, 4'd5, 4'd8, 4'd2},
      {4'd0, 4'd4, 4'd5, 4'd1, 4'd3},
      {4'd0, 4'd4, 4'd5, 4'd5, 4'd4},
      {4'd1, 4'd1, 4'd9, 4'd0, 4'd0},
      {4'd1, 4'd0, 4'd9, 4'd5, 4'd4},
      {4'd2, 4'd2, 4'd5, 4'd9, 4'd4},
      {4'd3, 4'd3, 4'd5, 4'd0, 4'd4},
      {4'd3, 4'd0, 4'd3, 4'd3, 4'd1},
      {4'd2, 4'd3, 4'd5, 4'd7, 4'd2},
      {4'd1, 4'd2, 4'd5, 4'd5, 4'd4}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [3:0] my_x = 4'd5;
   logic [3:0] my_y = 4'd5;
   logic [NPL*NP-1:0]    in_valid = '0;
   logic [NPL*NP*FW-1:0] in_data = '0;
   logic [NPL*NP-1:0]    in_ready;
   logic [NPL*NP-1:0]    out_valid;
   logic [NPL*NP*FW-1:0] out_data;
   logic [NPL*NP-1:0]    out_ready = '1;

   int n_chk = 0;
   int n_err = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fwd_node #(.NPLANE(NPL), .FLIT_W(FW), .DEPTH(4)) u0 (
      .clk(clk), .rst_n(rst_n), .my_x(my_x), .my_y(my_y),
      .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] flit(input logic [7:0] len, input logic [3:0] y,
                                        input logic [3:0] x);
      return {len, y, x};
   endfunction

   task automatic expect_e0(input logic [15:0] exp, input string req);
      chk(out_valid[0] && out_data[15:0] == exp, req, {out_valid[0], out_data[15:0]},
          {1'b1, exp});
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_err++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: during reset
      chk(out_valid == '0 && in_ready == '1, "R1 in reset", {out_valid, in_ready}, {20'd0, 20'hFFFFF});
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid == '0 && in_ready == '1, "R1 after reset", {out_valid, in_ready}, {20'd0, 20'hFFFFF});

      // Vector table: routing R2 R3 R4 R5, isolation R6, latency R10
      for (int v = 0; v < NV; v++) begin
         int pl, ip, ex, si, di;
         logic [3:0] dx, dy;
         string tag;
         pl = int'(VEC[v][19:16]);
         ip = int'(VEC[v][15:12]);
         dx = VEC[v][11:8];
         dy = VEC[v][7:4];
         ex = int'(VEC[v][3:0]);
         si = pl * NP + ip;
         di = pl * NP + ex;
         if (ex < 2)                       tag = "R2/R6/R10";
         else if (ex < 4)                  tag = "R3/R6/R10";
         else if (dx == 4'd5 && dy == 4'd5) tag = "R4/R6/R10";
         else                              tag = "R5/R6/R10";
         in_valid[si] = 1'b1;
         in_data[si*FW +: FW] = flit(8'd0, dy, dx);
         @(negedge clk);
         in_valid[si] = 1'b0;
         chk(out_valid == (20'd1 << di) && out_data[di*FW +: FW] == flit(8'd0, dy, dx),
             tag, {out_valid, out_data[di*FW +: FW]}, {20'd1 << di, flit(8'd0, dy, dx)});
         @(negedge clk);
         chk(out_valid == '0, "R6 idle after delivery", out_valid, 0);
      end

      // R7/R8/R9: two multi-flit packets contend for plane 0 East, output stalled
      out_ready[0] = 1'b0;
      in_valid[1] = 1'b1; in_data[1*FW +: FW] = flit(8'd1, 4'd0, 4'd9);
      in_valid[4] = 1'b1; in_data[4*FW +: FW] = flit(8'd2, 4'd1, 4'd9);
      @(negedge clk);
      in_data[1*FW +: FW] = 16'hB001;
      in_data[4*FW +: FW] = 16'hC001;
      @(negedge clk);
      in_valid[1] = 1'b0;
      in_data[4*FW +: FW] = 16'hC002;
      @(negedge clk);
      in_valid[4] = 1'b0;
      expect_e0(flit(8'd1, 4'd0, 4'd9), "R9 held under stall");
      @(negedge clk);
      expect_e0(flit(8'd1, 4'd0, 4'd9), "R9 still held");
      out_ready[0] = 1'b1;
      expect_e0(flit(8'd1, 4'd0, 4'd9), "R8 first winner input 1");
      @(negedge clk); expect_e0(16'hB001, "R7 body follows header");
      @(negedge clk); expect_e0(flit(8'd2, 4'd1, 4'd9), "R7 next packet header");
      @(negedge clk); expect_e0(16'hC001, "R7 body 1");
      @(negedge clk); expect_e0(16'hC002, "R7 body 2");
      @(negedge clk);
      chk(out_valid[0] == 1'b0, "R7 output idle after packets", out_valid[0], 0);

      // R8: alternation between two inputs holding two packets each
      out_ready[0] = 1'b0;
      in_valid[1] = 1'b1; in_data[1*FW +: FW] = flit(8'd0, 4'd1, 4'd9);
      in_valid[4] = 1'b1; in_data[4*FW +: FW] = flit(8'd0, 4'd2, 4'd9);
      @(negedge clk);
      in_data[1*FW +: FW] = flit(8'd0, 4'd3, 4'd9);
      in_data[4*FW +: FW] = flit(8'd0, 4'd4, 4'd9);
      @(negedge clk);
      in_valid[1] = 1'b0; in_valid[4] = 1'b0;
      out_ready[0] = 1'b1;
      for (int k = 1; k <= 4; k++) begin
         expect_e0(flit(8'd0, 4'(k), 4'd9), "R8 alternation order");
         @(negedge clk);
      end

      // R9: fill local FIFO of plane 0 while East stalls
      out_ready[0] = 1'b0;
      for (int k = 1; k <= 5; k++) begin
         in_valid[4] = 1'b1;
         in_data[4*FW +: FW] = flit(8'd0, 4'(k), 4'd9);
         @(negedge clk);
      end
      chk(in_ready[4] == 1'b0, "R9 in_ready low after four flits", in_ready[4], 0);
      out_ready[0] = 1'b1;
      expect_e0(flit(8'd0, 4'd1, 4'd9), "R9 drain 1");
      @(negedge clk);
      expect_e0(flit(8'd0, 4'd2, 4'd9), "R9 drain 2");
      @(negedge clk);
      in_valid[4] = 1'b0;
      for (int k = 3; k <= 5; k++) begin
         expect_e0(flit(8'd0, 4'(k), 4'd9), "R9 drain no loss");
         @(negedge clk);
      end
      chk(out_valid == '0, "R9 all drained", out_valid, 0);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule